// File: doc/BRIEF.md
# Block-Mode Word Transfer Engine

This engine moves a programmed number of 32-bit words between a word-aligned RAM port and a single peripheral port, one word per clock. Software-side logic elsewhere supplies a base byte address, a word count, a step direction and a transfer direction together with a one-cycle start pulse. The engine then walks the address one word up or down per transfer and raises a done pulse when the count is used up.

Two transfer directions exist. In the forward direction each word is read from RAM and, one cycle later when the read data returns, strobed into a graphics command port. In the table-clear direction the engine produces the data itself. It writes into RAM a chain of words, each pointing to the word one position below it, and closes the chain with an end marker. A depth-ordered drawing list can then be started from an empty, fully linked table.

Top module: `blk_dma_engine`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, `busy_o`, `done_o`, `mem_req_o`, `mem_we_o` and `gp_we_o` are all low.
- R2: A start pulse seen while `busy_o` is low is accepted: base, count, step and direction are captured and `busy_o` is high in the following cycle.
- R3: For a count N greater than zero, one RAM access (`mem_req_o` high) is issued in each of the N cycles after the accepting cycle. The first access goes to the base, and every `mem_addr_o` equals the running byte address ANDed with 0x1FFFFC.
- R4: After each word the running address changes by +4 when `step_dec_i` was 0 at start and by -4 when it was 1, wrapping modulo 2^32 before masking.
- R5: With `mode_i`=0 (RAM to peripheral), every access is a read (`mem_we_o`=0). `gp_we_o` is high in the cycle after each read, with `gp_data_o` equal to the `mem_rdata_i` returned in that cycle. No strobe occurs in other cycles.
- R6: With `mode_i`=1 (table clear), every access is a write (`mem_we_o`=1), and every word except the last carries (running address - 4) ANDed with 0x1FFFFF.
- R7: In table-clear mode the last word, written when one word remains, is 0x00FFFFFF.
- R8: `done_o` is high for exactly one cycle, the cycle after the last access. `busy_o` is still high in that cycle and low in the next one.
- R9: A start with a count of zero issues no access and gives the done pulse in the cycle after the accepting cycle.
- R10: A start pulse while `busy_o` is high is ignored, including in the done cycle. The running transfer keeps its addresses and word count, and no new transfer begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| base_i | input | 32 | Start byte address |
| count_i | input | 16 | Number of words to move |
| step_dec_i | input | 1 | 0: address steps up, 1: steps down |
| mode_i | input | 1 | 0: RAM to peripheral, 1: table clear into RAM |
| mem_req_o | output | 1 | RAM access request |
| mem_we_o | output | 1 | RAM write enable (1 write, 0 read) |
| mem_addr_o | output | 32 | RAM byte address, masked to 0x1FFFFC |
| mem_wdata_o | output | 32 | RAM write data |
| mem_rdata_i | input | 32 | RAM read data, valid one cycle after a read |
| gp_we_o | output | 1 | Graphics command port write strobe |
| gp_data_o | output | 32 | Graphics command port data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
In forward mode, the strobe for word k to the graphics port falls in the same cycle as the RAM read for word k+1. The strobe for the final word falls in the same cycle as the done pulse. Each forward transfer is therefore walked cycle by cycle. Every strobe's data is compared with the word the bench's RAM model holds at the address read one cycle earlier, and the done pulse must come exactly one cycle after the last access while that last strobe is still present. A start pulse is also driven both in mid-transfer and in the done cycle itself, and the address sequence, word count and idle state afterwards are required to be unchanged.

// File: rtl/blk_dma_pkg.sv
package blk_dma_pkg;

  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int WORD_BYTES = 4;

  localparam logic [31:0] RAM_ADDR_MASK = 32'h001F_FFFC;
  localparam logic [31:0] LINK_PTR_MASK = 32'h001F_FFFF;
  localparam logic [31:0] LINK_END_WORD = 32'h00FF_FFFF;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  typedef enum logic {
    XFER_TO_PERIPH = 1'b0,
    XFER_TBL_CLEAR = 1'b1
  } xfer_dir_e;

endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import blk_dma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             load_o,
  output logic             adv_o,
  output logic             last_o,
  output logic             busy_o,
  output logic             done_o
);

  seq_state_e       st_q, st_n;
  logic [CNT_W-1:0] rem_q, rem_n;
  logic             rem_en;

  // next-state logic
  always_comb begin
    st_n  = st_q;
    rem_n = rem_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          rem_n = count_i;
          st_n  = (count_i == '0) ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        rem_n = rem_q - CNT_W'(1);
        if (rem_q == CNT_W'(1)) begin
          st_n = ST_FIN;
        end
      end
      ST_FIN:  st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  assign load_o = (st_q == ST_IDLE) && start_i;
  assign adv_o  = (st_q == ST_RUN);
  assign last_o = (st_q == ST_RUN) && (rem_q == CNT_W'(1));
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_FIN);
  assign rem_en = load_o | adv_o;

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_n;
    end
  end

  // remaining-word counter, clock-enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_n;
    end
  end

endmodule

// File: rtl/dma_addr_walk.sv
module dma_addr_walk
  import blk_dma_pkg::*;
#(
  parameter int ADDR_W = blk_dma_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              dec_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [ADDR_W-1:0] ram_addr_o
);

  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] RAM_MASK = ADDR_W'(RAM_ADDR_MASK);

  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              dec_q;
  logic              addr_en;

  assign addr_en = load_i | adv_i;

  // next running address
  always_comb begin
    if (load_i) begin
      addr_n = base_i;
    end else if (dec_q) begin
      addr_n = addr_q - STEP;
    end else begin
      addr_n = addr_q + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q <= 1'b0;
    end else if (load_i) begin
      dec_q <= dec_i;
    end
  end

  assign cur_addr_o = addr_q;
  assign ram_addr_o = addr_q & RAM_MASK;

endmodule

// File: rtl/dma_word_path.sv
module dma_word_path
  import blk_dma_pkg::*;
#(
  parameter int ADDR_W = blk_dma_pkg::ADDR_W,
  parameter int DATA_W = blk_dma_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue_i,
  input  logic              last_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic              gp_we_o,
  output logic [DATA_W-1:0] gp_data_o
);

  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] PTR_MASK = ADDR_W'(LINK_PTR_MASK);
  localparam logic [DATA_W-1:0] END_WORD = DATA_W'(LINK_END_WORD);

  logic [ADDR_W-1:0] link_ptr;
  logic              rd_pend_q;

  // table-clear data source: pointer to the word below, end marker last
  assign link_ptr = (cur_addr_i - STEP) & PTR_MASK;
  assign wdata_o  = last_i ? END_WORD : DATA_W'(link_ptr);

  // read-return tracking for the peripheral strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
    end else begin
      rd_pend_q <= rd_issue_i;
    end
  end

  assign gp_we_o   = rd_pend_q;
  assign gp_data_o = rdata_i;

endmodule

// File: rtl/blk_dma_engine.sv
module blk_dma_engine
  import blk_dma_pkg::*;
#(
  parameter int ADDR_W = blk_dma_pkg::ADDR_W,
  parameter int DATA_W = blk_dma_pkg::DATA_W,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              step_dec_i,
  input  logic              mode_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              gp_we_o,
  output logic [DATA_W-1:0] gp_data_o,
  output logic              busy_o,
  output logic              done_o
);

  logic              load, adv, last;
  logic [ADDR_W-1:0] cur_addr;
  xfer_dir_e         dir_q;

  dma_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .count_i (count_i),
    .load_o  (load),
    .adv_o   (adv),
    .last_o  (last),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  dma_addr_walk #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .adv_i      (adv),
    .base_i     (base_i),
    .dec_i      (step_dec_i),
    .cur_addr_o (cur_addr),
    .ram_addr_o (mem_addr_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= XFER_TO_PERIPH;
    end else if (load) begin
      dir_q <= xfer_dir_e'(mode_i);
    end
  end

  dma_word_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_issue_i (adv && (dir_q == XFER_TO_PERIPH)),
    .last_i     (last),
    .cur_addr_i (cur_addr),
    .rdata_i    (mem_rdata_i),
    .wdata_o    (mem_wdata_o),
    .gp_we_o    (gp_we_o),
    .gp_data_o  (gp_data_o)
  );

  assign mem_req_o = adv;
  assign mem_we_o  = adv && (dir_q == XFER_TBL_CLEAR);

endmodule

// File: rtl/blk_dma_chk.sv
module blk_dma_chk
  import blk_dma_pkg::*;
#(
  parameter int ADDR_W = blk_dma_pkg::ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              step_dec_i,
  input logic              mode_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              gp_we_o,
  input logic              busy_o,
  input logic              done_o
);

  localparam logic [ADDR_W-1:0] MASK = ADDR_W'(RAM_ADDR_MASK);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic dec_c, mode_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_c  <= 1'b0;
      mode_c <= 1'b0;
    end else if (start_i && !busy_o) begin
      dec_c  <= step_dec_i;
      mode_c <= mode_i;
    end
  end

  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o && !gp_we_o); // R3

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && $past(mem_req_o) |->
      mem_addr_o == ((dec_c ? $past(mem_addr_o) - STEP : $past(mem_addr_o) + STEP) & MASK)); // R4

  AST_STROBE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    gp_we_o |-> $past(mem_req_o && !mem_we_o)); // R5

  AST_DIR_WRITE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> mem_we_o == mode_c); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o && !done_o); // R8

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o && !mem_req_o); // R8

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_o |=> busy_o); // R10

endmodule

bind blk_dma_engine blk_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .step_dec_i (step_dec_i),
  .mode_i     (mode_i),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .gp_we_o    (gp_we_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/tb_blk_dma_engine.sv
`timescale 1ns/1ps
module tb_blk_dma_engine;

  logic        clk, rst_n;
  logic        start_i, step_dec_i, mode_i;
  logic [31:0] base_i;
  logic [15:0] count_i;
  logic        mem_req_o, mem_we_o, gp_we_o, busy_o, done_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, gp_data_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  blk_dma_engine dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .count_i(count_i), .step_dec_i(step_dec_i), .mode_i(mode_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .gp_we_o(gp_we_o), .gp_data_o(gp_data_o), .busy_o(busy_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  function automatic logic [31:0] pat(input logic [7:0] i);
    return {8'h5A, 8'h3C ^ i, i, ~i};
  endfunction

  // RAM model: one cycle read latency
  logic [31:0] mem [256];
  logic        clr;
  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(8'(i));
    end else if (mem_req_o && mem_we_o) begin
      mem[mem_addr_o[9:2]] <= mem_wdata_o;
    end
    if (mem_req_o && !mem_we_o) mem_rdata_i <= mem[mem_addr_o[9:2]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inj: sampled cycle index at which a stray start is driven (-1 none)
  // inj_done: drive a stray start in the done cycle
  task automatic run_xfer(input logic [31:0] base, input logic [15:0] cnt,
                          input logic dec, input logic mode,
                          input int inj, input bit inj_done);
    logic [31:0] ea;
    logic [7:0]  prev_idx;
    logic        prev_rd;
    bit          seen_done;
    int          acc, gps, cyc, last_acc;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    start_i = 1'b1; base_i = base; count_i = cnt; step_dec_i = dec; mode_i = mode;
    @(negedge clk);
    start_i = 1'b0; base_i = 32'hDEAD_BEE0; count_i = 16'd9; step_dec_i = ~dec; mode_i = ~mode;
    chk("R2 busy after start", 32'(busy_o), 32'd1);
    ea = base; acc = 0; gps = 0; cyc = 0; last_acc = -1;
    prev_rd = 1'b0; prev_idx = '0; seen_done = 0;
    while (!seen_done && cyc < 2000) begin
      if (gp_we_o) begin
        gps++;
        chk("R5 strobe follows read", 32'(prev_rd), 32'd1);
        chk("R5 peripheral data", gp_data_o, pat(prev_idx));
      end else if (prev_rd) begin
        chk("R5 missing strobe", 32'(gp_we_o), 32'd1);
      end
      prev_rd = 1'b0;
      if (mem_req_o) begin
        chk("R3 R4 address", mem_addr_o, ea & 32'h001F_FFFC);
        chk(mode ? "R6 write kind" : "R5 read kind", 32'(mem_we_o), 32'(mode));
        if (mode) begin
          if (acc == int'(cnt) - 1) chk("R7 end marker", mem_wdata_o, 32'h00FF_FFFF);
          else chk("R6 link word", mem_wdata_o, (ea - 32'd4) & 32'h001F_FFFF);
        end else begin
          prev_rd = 1'b1;
          prev_idx = mem_addr_o[9:2];
        end
        ea = dec ? ea - 32'd4 : ea + 32'd4;
        acc++;
        last_acc = cyc;
      end
      if (done_o) begin
        seen_done = 1;
        chk("R8 R10 word count", 32'(acc), 32'(cnt));
        chk("R8 done timing", 32'(cyc), 32'(last_acc + 1));
        chk("R8 busy in done cycle", 32'(busy_o), 32'd1);
        chk("R5 strobe count", 32'(gps), mode ? 32'd0 : 32'(cnt));
        if (inj_done) begin start_i = 1'b1; base_i = 32'h400; count_i = 16'd3; end
      end
      if (cyc == inj) begin start_i = 1'b1; base_i = 32'h300; count_i = 16'd2; end
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end
    chk("R8 done seen", 32'(seen_done), 32'd1);
    chk("R8 busy low after done", 32'(busy_o), 32'd0);
    chk("R8 done single", 32'(done_o), 32'd0);
    @(negedge clk);
    chk("R10 no restart", 32'(busy_o | mem_req_o), 32'd0);
  endtask

  // {base, count, step_dec, mode}
  localparam int NV = 8;
  localparam logic [49:0] VEC [NV] = '{
    {32'h0000_0100, 16'd5, 1'b0, 1'b0},
    {32'h0000_01FC, 16'd4, 1'b1, 1'b0},
    {32'h0000_011C, 16'd8, 1'b1, 1'b1},
    {32'h0000_00F0, 16'd3, 1'b0, 1'b1},
    {32'h8020_0008, 16'd3, 1'b0, 1'b0},
    {32'h0000_0002, 16'd2, 1'b1, 1'b0},
    {32'h0000_0004, 16'd2, 1'b1, 1'b1},
    {32'h0000_0040, 16'd1, 1'b0, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; base_i = '0; count_i = '0;
    step_dec_i = 1'b0; mode_i = 1'b0; clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {27'd0, busy_o, done_o, mem_req_o, mem_we_o, gp_we_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {27'd0, busy_o, done_o, mem_req_o, mem_we_o, gp_we_o}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      run_xfer(VEC[v][49:18], VEC[v][17:2], VEC[v][1], VEC[v][0], -1, 0);
    end

    // R9: zero count
    start_i = 1'b1; base_i = 32'h80; count_i = 16'd0; mode_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R9 done next cycle", 32'(done_o), 32'd1);
    chk("R9 no access", 32'(mem_req_o), 32'd0);
    chk("R9 busy in done cycle", 32'(busy_o), 32'd1);
    @(negedge clk);
    chk("R9 idle after", 32'(busy_o | done_o | mem_req_o), 32'd0);

    // R10: stray start mid-transfer and in done cycle
    run_xfer(32'h200, 16'd6, 1'b0, 1'b0, 2, 1);
    run_xfer(32'h120, 16'd4, 1'b1, 1'b1, 0, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule